// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the transmit half of a network controller that moves data by direct memory access. Software builds a circular ring of 16-byte descriptors in system memory. Each descriptor points at a packet buffer. Software then moves a tail index forward, and that register write works as a doorbell. The engine owns every slot from its head index (inclusive) up to the tail (exclusive). For each slot it takes these steps in order:

1. Fetch the four descriptor words over a single-outstanding memory read port.
2. Read the buffer one 32-bit word at a time.
3. Send the bytes on a byte-stream port.
4. If the descriptor asks for it, store a done flag back into the descriptor and latch an interrupt cause.
5. Move the head forward by one, modulo the ring length.

A packet may be split across several consecutive descriptors. Only the descriptor that carries the end-of-packet flag ends the frame on the stream. Software keeps one slot free, so head equal to tail always means the engine has nothing to do.

Top module: `txr_engine`

## Requirements
- R1: After reset, head, tail, ring base, ring length and cause read as zero, and `irq`, `memReqValid`, `memWrValid` and `txValid` are low.
- R2: Descriptor n sits at ring base + 16*n and is read as four little-endian words at offsets 0, 4, 8 and 12:
  - Word 0 is the buffer address, with bits 1:0 ignored.
  - Word 1 is ignored.
  - Word 2 bits 15:0 are the byte length, bit 24 is end-of-packet and bit 27 is report-status.
  - Bit 0 of word 3 is the done flag.
- R3: Whenever head differs from tail, the engine processes descriptors. When head equals tail, it issues no memory request and sends no byte.
- R4: For each descriptor, the engine reads all four descriptor words, then the buffer words at ascending addresses. It sends the bytes of each buffer word lowest address first, exactly as many bytes as the length. Only after the last byte (and after any write-back) does the head advance.
- R5: The head advances by one per descriptor and returns to 0 after ring length - 1.
- R6: `txLast` is high only with the final byte of a descriptor whose end-of-packet bit is set. Descriptors without that bit continue the same packet.
- R7: When report-status is set, the engine issues one write to word 3 of that descriptor with byte mask 0001 and data 1, and sets the cause bit when that write is accepted. Without report-status, no write is issued and the cause is unchanged.
- R8: The cause bit is sticky, drives `irq`, and clears when the cause register (offset 4) is read.
- R9: A tail write that arrives while the engine is busy is taken up. Before each new descriptor, the head is compared with the latest tail.
- R10: A memory request holds its address until `memReqReady`. A stream byte holds its data and `txLast` until `txReady`.
- R11: The head register (offset 2) is read-only. Writes to it leave the head unchanged.
- R12: The register offsets are: 0 ring base (bits 3:0 read zero), 1 ring length in entries, 2 head, 3 tail, 4 cause (bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (read side effects) |
| regAddr | input | 3 | Register offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| memReqValid | output | 1 | Memory read request valid |
| memReqReady | input | 1 | Memory read request accepted |
| memReqAddr | output | AW | Byte address of requested word |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Read data word |
| memWrValid | output | 1 | Status write-back valid |
| memWrReady | input | 1 | Status write-back accepted |
| memWrAddr | output | AW | Byte address of write-back word |
| memWrData | output | 32 | Write-back data |
| memWrMask | output | 4 | Write-back byte enables |
| txValid | output | 1 | Stream byte valid |
| txReady | input | 1 | Stream byte accepted |
| txData | output | 8 | Stream byte |
| txLast | output | 1 | Final byte of a packet |
| irq | output | 1 | Transmit interrupt (cause bit) |

## Verification
The bench covers these corner cases:
- **Head wrapping at the ring end.** A design that got this wrong would walk off the ring into unrelated memory.
- **Fragmented packets.** A missing end-of-packet gate would mark a frame end after each fragment.
- **Tail doorbell arriving mid-descriptor.** A design that latched the tail once would stop short and strand a descriptor.
- **Write-back byte mask.** A full-word write would clobber the neighbouring status bytes.
- **Read-to-clear cause.** A cause that never clears would leave `irq` stuck high.

Stalls on both the memory and the stream handshakes check that data stays put while a transfer waits.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_DREQ, S_DWAIT, S_BREQ, S_BWAIT, S_SEND, S_WB, S_ADV
  } txrState_t;

  typedef struct packed {
    logic startDesc;
    logic reqBuf;
    logic latchDesc;
    logic latchBuf;
    logic emitByte;
    logic setCause;
    logic advance;
  } txrStrobes_t;

  localparam logic [2:0] REG_BASE  = 3'd0;
  localparam logic [2:0] REG_LEN   = 3'd1;
  localparam logic [2:0] REG_HEAD  = 3'd2;
  localparam logic [2:0] REG_TAIL  = 3'd3;
  localparam logic [2:0] REG_CAUSE = 3'd4;

  localparam int BIT_EOP = 24;
  localparam int BIT_RS  = 27;
endpackage

// File: rtl/txr_ctrl.sv
module txr_ctrl
  import txr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ringEmpty,
  input  logic        descIdxLast,
  input  logic        lenZero,
  input  logic        rsFlag,
  input  logic        lastByte,
  input  logic        wordDone,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        memWrReady,
  input  logic        txReady,
  output logic        memReqValid,
  output logic        memWrValid,
  output logic        txValid,
  output txrStrobes_t strb
);
  txrState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    strb        = '0;
    memReqValid = 1'b0;
    memWrValid  = 1'b0;
    txValid     = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (!ringEmpty) begin
          strb.startDesc = 1'b1;
          nextState      = S_DREQ;
        end
      end
      S_DREQ: begin
        memReqValid = 1'b1;
        if (memReqReady) nextState = S_DWAIT;
      end
      S_DWAIT: begin
        if (memRspValid) begin
          strb.latchDesc = 1'b1;
          if (!descIdxLast)  nextState = S_DREQ;
          else if (!lenZero) nextState = S_BREQ;
          else               nextState = rsFlag ? S_WB : S_ADV;
        end
      end
      S_BREQ: begin
        memReqValid = 1'b1;
        strb.reqBuf = 1'b1;
        if (memReqReady) nextState = S_BWAIT;
      end
      S_BWAIT: begin
        if (memRspValid) begin
          strb.latchBuf = 1'b1;
          nextState     = S_SEND;
        end
      end
      S_SEND: begin
        txValid = 1'b1;
        if (txReady) begin
          strb.emitByte = 1'b1;
          if (lastByte)      nextState = rsFlag ? S_WB : S_ADV;
          else if (wordDone) nextState = S_BREQ;
        end
      end
      S_WB: begin
        memWrValid = 1'b1;
        if (memWrReady) begin
          strb.setCause = 1'b1;
          nextState     = S_ADV;
        end
      end
      S_ADV: begin
        strb.advance = 1'b1;
        nextState    = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end
endmodule

// File: rtl/txr_dp.sv
module txr_dp
  import txr_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 8,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  txrStrobes_t   strb,
  input  logic          regWrEn,
  input  logic          regRdEn,
  input  logic [2:0]    regAddr,
  input  logic [31:0]   regWrData,
  output logic [31:0]   regRdData,
  input  logic [31:0]   memRspData,
  output logic [AW-1:0] memReqAddr,
  output logic [AW-1:0] memWrAddr,
  output logic [7:0]    txData,
  output logic          txLast,
  output logic          ringEmpty,
  output logic          descIdxLast,
  output logic          lenZero,
  output logic          rsFlag,
  output logic          lastByte,
  output logic          wordDone,
  output logic          irq,
  output logic [IW-1:0] headIdx,
  output logic [IW-1:0] ringLen
);
  localparam int DESC_SHIFT = 4;

  logic [AW-1:0] baseQ, bufPtr, descBase;
  logic [IW-1:0] headQ, tailQ, lenQ, headInc;
  logic [LW-1:0] remain;
  logic [31:0]   wordQ;
  logic [1:0]    descIdx, bytePos;
  logic          causeQ, eopQ, rsQ;

  assign descBase = baseQ + (AW'(headQ) << DESC_SHIFT);
  assign headInc  = headQ + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0; lenQ <= '0; headQ <= '0; tailQ <= '0; causeQ <= 1'b0;
    end else begin
      if (regWrEn) begin
        case (regAddr)
          REG_BASE: baseQ <= {regWrData[AW-1:DESC_SHIFT], {DESC_SHIFT{1'b0}}};
          REG_LEN:  lenQ  <= regWrData[IW-1:0];
          REG_TAIL: tailQ <= regWrData[IW-1:0];
          default: ;
        endcase
      end
      if (strb.setCause)                              causeQ <= 1'b1;
      else if (regRdEn && regAddr == REG_CAUSE)       causeQ <= 1'b0;
      if (strb.advance) headQ <= (headInc == lenQ) ? '0 : headInc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descIdx <= '0; bufPtr <= '0; remain <= '0; eopQ <= 1'b0; rsQ <= 1'b0;
      wordQ <= '0; bytePos <= '0;
    end else begin
      if (strb.startDesc) descIdx <= '0;
      if (strb.latchDesc) begin
        descIdx <= descIdx + 1'b1;
        case (descIdx)
          2'd0: bufPtr <= {memRspData[AW-1:2], 2'b00};
          2'd2: begin
            remain <= memRspData[LW-1:0];
            eopQ   <= memRspData[BIT_EOP];
            rsQ    <= memRspData[BIT_RS];
          end
          default: ;
        endcase
      end
      if (strb.latchBuf) begin
        wordQ   <= memRspData;
        bytePos <= '0;
        bufPtr  <= bufPtr + AW'(4);
      end
      if (strb.emitByte) begin
        remain  <= remain - 1'b1;
        bytePos <= bytePos + 1'b1;
      end
    end
  end

  always_comb begin
    case (regAddr)
      REG_BASE:  regRdData = 32'(baseQ);
      REG_LEN:   regRdData = 32'(lenQ);
      REG_HEAD:  regRdData = 32'(headQ);
      REG_TAIL:  regRdData = 32'(tailQ);
      REG_CAUSE: regRdData = {31'd0, causeQ};
      default:   regRdData = '0;
    endcase
  end

  assign memReqAddr  = strb.reqBuf ? bufPtr : descBase + (AW'(descIdx) << 2);
  assign memWrAddr   = descBase + AW'(12);
  assign txData      = wordQ[8*bytePos +: 8];
  assign txLast      = eopQ && (remain == LW'(1));
  assign ringEmpty   = (headQ == tailQ);
  assign descIdxLast = (descIdx == 2'd3);
  assign lenZero     = (remain == '0);
  assign rsFlag      = rsQ;
  assign lastByte    = (remain == LW'(1));
  assign wordDone    = (bytePos == 2'd3);
  assign irq         = causeQ;
  assign headIdx     = headQ;
  assign ringLen     = lenQ;
endmodule

// File: rtl/txr_engine.sv
module txr_engine
  import txr_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 8,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic          regRdEn,
  input  logic [2:0]    regAddr,
  input  logic [31:0]   regWrData,
  output logic [31:0]   regRdData,
  output logic          memReqValid,
  input  logic          memReqReady,
  output logic [AW-1:0] memReqAddr,
  input  logic          memRspValid,
  input  logic [31:0]   memRspData,
  output logic          memWrValid,
  input  logic          memWrReady,
  output logic [AW-1:0] memWrAddr,
  output logic [31:0]   memWrData,
  output logic [3:0]    memWrMask,
  output logic          txValid,
  input  logic          txReady,
  output logic [7:0]    txData,
  output logic          txLast,
  output logic          irq
);
  txrStrobes_t   strb;
  logic          ringEmpty, descIdxLast, lenZero, rsFlag, lastByte, wordDone;
  logic [IW-1:0] headIdx, ringLen;

  assign memWrData = 32'h0000_0001;
  assign memWrMask = 4'b0001;

  txr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ringEmpty(ringEmpty), .descIdxLast(descIdxLast),
    .lenZero(lenZero), .rsFlag(rsFlag), .lastByte(lastByte), .wordDone(wordDone),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .memWrReady(memWrReady),
    .txReady(txReady), .memReqValid(memReqValid), .memWrValid(memWrValid),
    .txValid(txValid), .strb(strb)
  );

  txr_dp #(.AW(AW), .IW(IW), .LW(LW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .memRspData(memRspData), .memReqAddr(memReqAddr), .memWrAddr(memWrAddr),
    .txData(txData), .txLast(txLast), .ringEmpty(ringEmpty),
    .descIdxLast(descIdxLast), .lenZero(lenZero), .rsFlag(rsFlag),
    .lastByte(lastByte), .wordDone(wordDone), .irq(irq),
    .headIdx(headIdx), .ringLen(ringLen)
  );
endmodule

// File: rtl/txr_engine_chk.sv
module txr_engine_chk #(
  parameter int AW = 32,
  parameter int IW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          memReqValid,
  input logic          memReqReady,
  input logic [AW-1:0] memReqAddr,
  input logic          memWrValid,
  input logic          memWrReady,
  input logic          txValid,
  input logic          txReady,
  input logic [7:0]    txData,
  input logic          txLast,
  input logic          irq,
  input logic [IW-1:0] headIdx,
  input logic [IW-1:0] ringLen
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));

  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txData) && $stable(txLast));

  // R5
  head_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    headIdx != $past(headIdx) |->
      headIdx == ((IW'($past(headIdx) + 1'b1) == $past(ringLen)) ? '0
                  : IW'($past(headIdx) + 1'b1)));

  // R4
  head_after_bytes_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |=> $stable(headIdx));

  // R4
  one_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memReqValid && txValid));

  // R7
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(memWrValid && memWrReady));
endmodule

bind txr_engine txr_engine_chk #(.AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rstN(rstN), .memReqValid(memReqValid), .memReqReady(memReqReady),
  .memReqAddr(memReqAddr), .memWrValid(memWrValid), .memWrReady(memWrReady),
  .txValid(txValid), .txReady(txReady), .txData(txData), .txLast(txLast),
  .irq(irq), .headIdx(headIdx), .ringLen(ringLen)
);

// File: tb/txr_engine_bench.sv
`timescale 1ns/1ps
module txr_engine_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic        memReqValid, memReqReady, memRspValid;
  logic [31:0] memReqAddr, memRspData, memWrAddr, memWrData;
  logic        memWrValid, memWrReady;
  logic [3:0]  memWrMask;
  logic        txValid, txReady, txLast, irq;
  logic [7:0]  txData;

  int checks = 0, errors = 0, cyc = 0;
  logic stall = 1'b0;

  logic [31:0] mem [0:255];
  logic        tbWrEn = 1'b0;
  logic [7:0]  tbWrIdx = '0;
  logic [31:0] tbWrVal = '0;
  logic [7:0]  capData [0:63];
  logic        capLast [0:63];
  int          capCount = 0;

  always #10 clk = ~clk;

  txr_engine u_txr_engine (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .memWrValid(memWrValid),
    .memWrReady(memWrReady), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .memWrMask(memWrMask), .txValid(txValid), .txReady(txReady), .txData(txData),
    .txLast(txLast), .irq(irq)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  assign memReqReady = stall ? (cyc[0] ^ cyc[2]) : 1'b1;
  assign memWrReady  = stall ? cyc[1] : 1'b1;
  assign txReady     = stall ? (cyc[0] | cyc[3]) : 1'b1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    memRspValid <= 1'b0;
    if (memReqValid && memReqReady) begin
      memRspValid <= 1'b1;
      memRspData  <= mem[memReqAddr[9:2]];
    end
    if (memWrValid && memWrReady)
      for (int b = 0; b < 4; b++)
        if (memWrMask[b]) mem[memWrAddr[9:2]][8*b +: 8] <= memWrData[8*b +: 8];
    if (tbWrEn) mem[tbWrIdx] <= tbWrVal;
    if (txValid && txReady && capCount < 64) begin
      capData[capCount] <= txData;
      capLast[capCount] <= txLast;
      capCount <= capCount + 1;
    end
  end

  initial begin
    for (int w = 0; w < 256; w++)
      mem[w] = (w < 64) ? {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)} : 32'h0;
  end

  always @(posedge clk) begin
    if (cyc == 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog R3 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic memPut(input int idx, input logic [31:0] val);
    @(negedge clk); tbWrEn = 1'b1; tbWrIdx = 8'(idx); tbWrVal = val;
    @(negedge clk); tbWrEn = 1'b0;
  endtask

  // ring base 0x100 -> word 64; descriptor n at words 64+4n..67+4n (R2)
  task automatic setDesc(input int n, input int bufA, input int len, input bit eop, input bit rs);
    memPut(64 + 4*n, 32'(bufA));
    memPut(65 + 4*n, 32'hDEAD_BEEF);
    memPut(66 + 4*n, (32'(rs) << 27) | (32'(eop) << 24) | 32'(len));
    memPut(67 + 4*n, 32'h0000_AB00);
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; regRdEn = 1'b1; #1 d = regRdData;
    @(negedge clk); regRdEn = 1'b0;
  endtask

  task automatic waitHead(input int target);
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      readReg(3'd2, v);
      if (v == 32'(target)) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic checkBytes(input int start, input int bufA, input int len, input bit eop, input string req);
    for (int k = 0; k < len; k++) begin
      check(capData[start+k] == pat(bufA+k), req, capData[start+k], pat(bufA+k));
      check(capLast[start+k] == (eop && k == len-1), "R6", capLast[start+k], eop && k == len-1);
    end
  endtask

  task automatic testReset;
    logic [31:0] v;
    for (int a = 0; a < 5; a++) begin
      readReg(3'(a), v);
      check(v == 0, "R1 reg", v, 0);
    end
    check(!irq && !memReqValid && !memWrValid && !txValid, "R1 outputs",
          {irq, memReqValid, memWrValid, txValid}, 0);
  endtask

  task automatic testSingle;
    logic [31:0] v;
    int s;
    setDesc(0, 'h00, 6, 1, 1);
    s = capCount;
    writeReg(3'd3, 1);
    waitHead(1);
    check(capCount - s == 6, "R4 count", capCount - s, 6);
    checkBytes(s, 'h00, 6, 1, "R4 data");
    check(mem[67] == 32'h0000_AB01, "R7 writeback", mem[67], 32'h0000_AB01);
    check(irq == 1'b1, "R8 irq", irq, 1);
    readReg(3'd4, v);
    check(v == 1, "R8 cause", v, 1);
    check(irq == 1'b0, "R8 clear", irq, 0);
  endtask

  task automatic testFragments;
    int s;
    setDesc(1, 'h20, 3, 0, 0);
    setDesc(2, 'h41, 5, 1, 0);
    stall = 1'b1;
    s = capCount;
    writeReg(3'd3, 3);
    waitHead(3);
    stall = 1'b0;
    check(capCount - s == 8, "R6 count", capCount - s, 8);
    checkBytes(s, 'h20, 3, 0, "R2 frag1");
    checkBytes(s + 3, 'h40, 5, 1, "R2 frag2 aligned");
    check(mem[71] == 32'h0000_AB00 && mem[75] == 32'h0000_AB00, "R7 no writeback",
          mem[71], 32'h0000_AB00);
    check(irq == 1'b0, "R7 no irq", irq, 0);
  endtask

  task automatic testTailBusy;
    logic [31:0] v;
    int s;
    setDesc(3, 'h60, 9, 1, 0);
    setDesc(4, 'h80, 2, 1, 1);
    s = capCount;
    writeReg(3'd3, 4);
    repeat (3) @(negedge clk);
    writeReg(3'd3, 5);
    waitHead(5);
    check(capCount - s == 11, "R9 count", capCount - s, 11);
    checkBytes(s, 'h60, 9, 1, "R9 d3");
    checkBytes(s + 9, 'h80, 2, 1, "R9 d4");
    check(mem[79] == 32'h0000_AB00, "R7 d3 untouched", mem[79], 32'h0000_AB00);
    check(mem[83] == 32'h0000_AB01, "R7 d4 written", mem[83], 32'h0000_AB01);
    readReg(3'd4, v);
    check(v == 1, "R8 cause busy", v, 1);
  endtask

  task automatic testWrap;
    logic [31:0] v;
    int s;
    setDesc(5, 'h90, 1, 1, 0);
    setDesc(6, 'hA0, 1, 1, 0);
    setDesc(7, 'hB0, 1, 1, 0);
    setDesc(0, 'hC0, 1, 1, 0);
    s = capCount;
    writeReg(3'd3, 1);
    waitHead(1);
    readReg(3'd2, v);
    check(v == 1, "R5 head wrap", v, 1);
    check(capCount - s == 4, "R5 count", capCount - s, 4);
    checkBytes(s + 2, 'hB0, 1, 1, "R5 slot7");
    checkBytes(s + 3, 'hC0, 1, 1, "R5 slot0");
  endtask

  task automatic testIdleAndHead;
    logic [31:0] v;
    int s;
    bit sawReq;
    s = capCount;
    sawReq = 0;
    writeReg(3'd2, 5);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (memReqValid) sawReq = 1;
    end
    readReg(3'd2, v);
    check(v == 1, "R11 head readonly", v, 1);
    check(!sawReq, "R3 idle no request", sawReq, 0);
    check(capCount == s, "R3 idle no bytes", capCount, s);
    readReg(3'd0, v);
    check(v == 32'h100, "R12 base", v, 32'h100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    writeReg(3'd0, 32'h0000_0107);
    writeReg(3'd1, 8);
    testSingle();
    testFragments();
    testTailBusy();
    testWrap();
    testIdleAndHead();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule